// File: doc/BRIEF.md
# Segmented-Paging Address Translator with Associative Cache

The block turns a 20-bit logical address into a 20-bit physical address through two table levels. The top four bits pick a segment. The middle eight bits pick a page within that segment. The low eight bits are a word offset that passes through unchanged. The physical address is a 12-bit block number joined to that offset.

A small fully associative translation cache is looked up first. Its key is the segment number and the page number together. On a hit the block number comes straight from the cache, and no table access is made. On a miss a walker makes two reads over one synchronous table read port:
- The first read fetches the segment's page-table base.
- The second read fetches the page entry, at an address formed by adding the page number to that base.

A present page entry is installed in the cache and answered. An absent one is answered as a fault.

The table port uses a 13-bit address. Bit 12 chooses the table: 0 is the segment table and 1 is the page table. The low 12 bits are the index. Read data arrives on the cycle after `tbl_rd_o`.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `busy_o`, `rsp_valid_o` and `tbl_rd_o` are 0 and every cache entry is invalid, so the first request of any key misses.
- R2: A request accepted while `busy_o`=0 that misses drives, in the next cycle, `tbl_rd_o`=1 and `tbl_addr_o` = {1'b0, 8'h00, segment}.
- R3: In the cycle after the segment read, `tbl_rd_o`=1 and `tbl_addr_o` = {1'b1, (base + page) mod 4096}, where base is bits [11:0] of the segment entry.
- R4: In the case of a miss, a page entry with bit 15 = 1 gives a response 4 cycles after acceptance, with `rsp_valid_o`=1, `rsp_hit_o`=0, `rsp_fault_o`=0 and `rsp_paddr_o` = {entry[11:0], offset}.
- R5: A page entry with bit 15 = 0 gives `rsp_fault_o`=1, `rsp_paddr_o`=0 and `rsp_hit_o`=0. It is not installed, so the same key misses again.
- R6: A request whose segment and page both match a valid entry responds in the next cycle with `rsp_hit_o`=1 and the cached block joined to the new offset, and makes no table read. The same page number in a different segment does not hit.
- R7: The cache has 8 entries, filled in round-robin order from entry 0. The ninth install after reset or flush replaces the first one installed.
- R8: A one-cycle `flush_i` invalidates every entry and restarts the fill order at entry 0, so a key that hit before the flush misses afterwards.
- R9: A request presented while `busy_o`=1 is ignored. It neither changes the walk in progress nor enters the cache.
- R10: `rsp_valid_o` is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cache entries |
| req_valid_i | input | 1 | Translation request strobe |
| req_laddr_i | input | 20 | Logical address {segment, page, offset} |
| busy_o | output | 1 | Walk in progress; requests are ignored |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | 13 | Table address: {table select, index} |
| tbl_rdata_i | input | 16 | Table read data, one cycle after the strobe |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Response came from the cache |
| rsp_fault_o | output | 1 | Page not present |
| rsp_paddr_o | output | 20 | Physical address {block, offset} |

## Verification
The bench targets the following cases:
- **Page-entry address formed by carry.** A segment base near the top of the page table plus a large page number must wrap modulo 4096. A design that concatenates base and page, or drops the carry, reads the wrong page entry.
- **Key width.** The same page number is tried under two segments. A cache keyed on the page alone would return a false hit.
- **Faulting entries.** These are requested twice. A design that installs a fault would hit on the second try.
- **Replacement and flush.** A ninth install must evict the oldest entry while keeping the others. A flush must turn a hit into a miss.
- **Busy window.** Requests held during a walk must neither corrupt the walk nor appear as cached or answered.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_SEG  = 2'd1,
    WK_PAGE = 2'd2,
    WK_FILL = 2'd3
  } walk_state_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int KEY_W   = 12,
  parameter int BLK_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [KEY_W-1:0] look_key_i,
  output logic             hit_o,
  output logic [BLK_W-1:0] hit_blk_o,
  input  logic             fill_i,
  input  logic [KEY_W-1:0] fill_key_i,
  input  logic [BLK_W-1:0] fill_blk_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [BLK_W-1:0]   blk_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   ptr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign hit_vec[e] = valid_q[e] && (key_q[e] == look_key_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        key_q[e]   <= '0;
        blk_q[e]   <= '0;
      end else if (flush_i) begin
        valid_q[e] <= 1'b0;
      end else if (fill_i && ptr_q == IDX_W'(e)) begin
        valid_q[e] <= 1'b1;
        key_q[e]   <= fill_key_i;
        blk_q[e]   <= fill_blk_i;
      end
    end
  end

  // keys are unique, so OR-merge of the hit lanes is safe
  always_comb begin
    hit_blk_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) hit_blk_o = hit_blk_o | blk_q[e];
    end
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (flush_i) ptr_q <= '0;
    else if (fill_i)  ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  a_r6_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  a_r7_rr_install: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> (valid_q[$past(ptr_q)] && key_q[$past(ptr_q)] == $past(fill_key_i)));
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int BLK_W   = 12,
  parameter int PTB_W   = 12,
  parameter int TDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [PAGE_W-1:0]  page_i,
  output logic               busy_o,
  output logic               tbl_rd_o,
  output logic [PTB_W:0]     tbl_addr_o,
  input  logic [TDATA_W-1:0] tbl_rdata_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [BLK_W-1:0]   blk_o
);
  walk_state_e state_q, state_d;
  logic        unused_rdata;

  assign unused_rdata = ^tbl_rdata_i[TDATA_W-2:BLK_W];

  always_comb begin
    state_d    = state_q;
    tbl_rd_o   = 1'b0;
    tbl_addr_o = '0;
    done_o     = 1'b0;
    unique case (state_q)
      WK_IDLE: if (start_i) state_d = WK_SEG;
      WK_SEG: begin
        tbl_rd_o   = 1'b1;
        tbl_addr_o = {1'b0, PTB_W'(seg_i)};
        state_d    = WK_PAGE;
      end
      WK_PAGE: begin
        // base added to page number, carry into high bits, wrap at table end
        tbl_rd_o   = 1'b1;
        tbl_addr_o = {1'b1, tbl_rdata_i[PTB_W-1:0] + PTB_W'(page_i)};
        state_d    = WK_FILL;
      end
      WK_FILL: begin
        done_o  = 1'b1;
        state_d = WK_IDLE;
      end
      default: state_d = WK_IDLE;
    endcase
  end

  assign fault_o = done_o && !tbl_rdata_i[TDATA_W-1];
  assign blk_o   = tbl_rdata_i[BLK_W-1:0];
  assign busy_o  = (state_q != WK_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WK_IDLE;
    else         state_q <= state_d;
  end

  a_r3_page_after_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_rd_o && !tbl_addr_o[PTB_W]) |=> (tbl_rd_o && tbl_addr_o[PTB_W]));

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (state_q != WK_SEG));
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 8,
  parameter int OFF_W       = 8,
  parameter int BLK_W       = 12,
  parameter int PTB_W       = 12,
  parameter int TDATA_W     = 16,
  parameter int TLB_ENTRIES = 8,
  localparam int LA_W  = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W  = BLK_W + OFF_W,
  localparam int TA_W  = PTB_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               req_valid_i,
  input  logic [LA_W-1:0]    req_laddr_i,
  output logic               busy_o,
  output logic               tbl_rd_o,
  output logic [TA_W-1:0]    tbl_addr_o,
  input  logic [TDATA_W-1:0] tbl_rdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic               rsp_fault_o,
  output logic [PA_W-1:0]    rsp_paddr_o
);
  localparam int KEY_W = SEG_W + PAGE_W;

  logic             accept, tlb_hit, walk_start;
  logic [BLK_W-1:0] tlb_blk;
  logic [LA_W-1:0]  laddr_q;
  logic             walk_done, walk_fault, fill;
  logic [BLK_W-1:0] walk_blk;

  assign accept     = req_valid_i && !busy_o;
  assign walk_start = accept && !tlb_hit;
  assign fill       = walk_done && !walk_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    laddr_q <= '0;
    else if (accept) laddr_q <= req_laddr_i;
  end

  xlate_tlb #(
    .KEY_W  (KEY_W),
    .BLK_W  (BLK_W),
    .ENTRIES(TLB_ENTRIES)
  ) i_tlb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .look_key_i(req_laddr_i[LA_W-1:OFF_W]),
    .hit_o     (tlb_hit),
    .hit_blk_o (tlb_blk),
    .fill_i    (fill),
    .fill_key_i(laddr_q[LA_W-1:OFF_W]),
    .fill_blk_i(walk_blk)
  );

  xlate_walk #(
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .BLK_W  (BLK_W),
    .PTB_W  (PTB_W),
    .TDATA_W(TDATA_W)
  ) i_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (walk_start),
    .seg_i      (laddr_q[LA_W-1 -: SEG_W]),
    .page_i     (laddr_q[OFF_W +: PAGE_W]),
    .busy_o     (busy_o),
    .tbl_rd_o   (tbl_rd_o),
    .tbl_addr_o (tbl_addr_o),
    .tbl_rdata_i(tbl_rdata_i),
    .done_o     (walk_done),
    .fault_o    (walk_fault),
    .blk_o      (walk_blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && tlb_hit) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b1;
        rsp_fault_o <= 1'b0;
        rsp_paddr_o <= {tlb_blk, req_laddr_i[OFF_W-1:0]};
      end else if (walk_done) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b0;
        rsp_fault_o <= walk_fault;
        rsp_paddr_o <= walk_fault ? '0 : {walk_blk, laddr_q[OFF_W-1:0]};
      end
    end
  end

  a_r2_seg_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !tlb_hit) |=>
      (tbl_rd_o && !tbl_addr_o[TA_W-1] && tbl_addr_o[SEG_W-1:0] == $past(req_laddr_i[LA_W-1 -: SEG_W])));

  a_r4_rsp_after_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_rd_o && tbl_addr_o[TA_W-1]) |=> ##1 (rsp_valid_o && !rsp_hit_o));

  a_r5_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0 && !rsp_hit_o));

  a_r6_hit_no_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && tlb_hit) |=> (rsp_valid_o && rsp_hit_o && !tbl_rd_o));
endmodule

// File: tb/test_seg_page_xlate.sv
module test_seg_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_laddr = '0;
  logic        busy, tbl_rd, rsp_valid, rsp_hit, rsp_fault;
  logic [12:0] tbl_addr;
  logic [15:0] tbl_rdata;
  logic [19:0] rsp_paddr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_page_xlate i_seg_page_xlate (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_laddr_i(req_laddr), .busy_o(busy),
    .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_rdata_i(tbl_rdata),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr)
  );

  // table model: segment s -> base {s,8'h80}; page entry absent when low nibble is D
  function automatic logic [11:0] seg_base(logic [3:0] s);
    return {s, 8'h80};
  endfunction
  function automatic logic [15:0] pte_word(logic [11:0] a);
    return {(a[3:0] != 4'hD), 3'b000, a ^ 12'hA5C};
  endfunction

  always_ff @(posedge clk)
    if (tbl_rd)
      tbl_rdata <= tbl_addr[12] ? pte_word(tbl_addr[11:0]) : {4'h0, seg_base(tbl_addr[3:0])};

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_walk_rsp(logic [19:0] la);
    logic [11:0] pa;
    logic [15:0] e;
    pa = seg_base(la[19:16]) + {4'h0, la[15:8]};
    e  = pte_word(pa);
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R4", "miss rsp valid/hit", {rsp_valid, rsp_hit}, 2'b10);
    chk(rsp_fault == !e[15], "R5", "fault flag", rsp_fault, !e[15]);
    chk(rsp_paddr == (e[15] ? {e[11:0], la[7:0]} : 20'h0), e[15] ? "R4" : "R5", "paddr",
        rsp_paddr, e[15] ? {e[11:0], la[7:0]} : 20'h0);
  endtask

  task automatic do_req(logic [19:0] la, bit exp_hit);
    logic [11:0] pa;
    pa = seg_base(la[19:16]) + {4'h0, la[15:8]};
    @(negedge clk);
    chk(busy == 1'b0, "R9", "idle before request", busy, 0);
    req_valid = 1'b1;
    req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(rsp_valid && rsp_hit, "R6", "hit response", {rsp_valid, rsp_hit}, 2'b11);
      chk(tbl_rd == 1'b0, "R6", "no table read on hit", tbl_rd, 0);
      chk(rsp_paddr == {pte_word(pa)[11:0], la[7:0]}, "R6", "hit paddr", rsp_paddr,
          {pte_word(pa)[11:0], la[7:0]});
    end else begin
      chk(tbl_rd && tbl_addr == {1'b0, 8'h00, la[19:16]}, "R2", "segment read",
          {tbl_rd, tbl_addr}, {1'b1, 1'b0, 8'h00, la[19:16]});
      chk(rsp_valid == 1'b0, "R6", "miss gives no early response", rsp_valid, 0);
      @(negedge clk);
      chk(tbl_rd && tbl_addr == {1'b1, pa}, "R3", "page read", {tbl_rd, tbl_addr}, {1'b1, 1'b1, pa});
      @(negedge clk);
      chk(rsp_valid == 1'b0 && tbl_rd == 1'b0, "R4", "fill cycle quiet", {rsp_valid, tbl_rd}, 0);
      @(negedge clk);
      check_walk_rsp(la);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "response is one pulse", rsp_valid, 0);
  endtask

  // {logical address, expect hit}
  localparam logic [20:0] VECS [17] = '{
    {20'h12345, 1'b0},  // R1 first ever request misses
    {20'h12399, 1'b1},  // R6 same key, new offset
    {20'h22345, 1'b0},  // R6 same page, other segment
    {20'h12400, 1'b0},
    {20'hF9012, 1'b0},  // R3 base F80 + 90 wraps to 010
    {20'h223FF, 1'b1},
    {20'h30D10, 1'b0},  // R5 absent page
    {20'h30D10, 1'b0},  // R5 not installed
    {20'h40001, 1'b0},
    {20'h50002, 1'b0},
    {20'h60003, 1'b0},
    {20'h70004, 1'b0},  // R7 eighth install
    {20'h12300, 1'b1},
    {20'h80005, 1'b0},  // R7 replaces entry 0 (key 1/23)
    {20'h12300, 1'b0},  // R7 evicted, replaces entry 1 (key 2/23)
    {20'h12477, 1'b1},  // R7 entry 2 kept
    {20'h22301, 1'b0}   // R7 evicted
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && rsp_valid == 1'b0 && tbl_rd == 1'b0, "R1", "reset outputs",
        {busy, rsp_valid, tbl_rd}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 17; i++) do_req(VECS[i][20:1], VECS[i][0]);

    // R9: requests held during a walk are ignored
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = 20'h90010;
    @(negedge clk);
    req_laddr = 20'hA0020;
    chk(busy && tbl_addr == 13'h0009, "R9", "walk started for first request", tbl_addr, 13'h0009);
    @(negedge clk);
    chk(tbl_addr == {1'b1, 12'h980}, "R9", "page read keeps walk key", tbl_addr, {1'b1, 12'h980});
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_walk_rsp(20'h90010);
    do_req(20'hA0020, 1'b0);  // R9 ignored request was not cached

    // R8 flush
    do_req(20'h80005, 1'b1);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_req(20'h80005, 1'b0);  // R8 misses after flush
    do_req(20'h80005, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule